// File: doc/BRIEF.md
# Load Address Conflict Gate

This block decides, in the same cycle, whether a pending load may start its memory access. It looks at every slot of a circular reorder window and picks out the stores that are older than the load. Age is measured as the ring distance from the current head pointer. A load must wait behind any such store whose destination address equals the load's address. It must also wait behind any such store whose address has not been computed yet. That second rule keeps load address resolution in program order with respect to earlier stores.

Stores write memory only when they retire at the head, so write-after-write and write-after-read hazards through memory never arise. This gate guards only the read-after-write case. A stalled load proceeds once the blocking store has left the window. A slot that retires or is flushed in the current cycle is ignored straight away. The gate holds no state. It is a parallel compare across all slots followed by a reduction.

Top module: `ldcheck_gate`

## Requirements
- R1: `ld_go` is 1 exactly when `ld_req` is 1 and no slot blocks the load; with `ld_req` at 0, `ld_go`, `ld_hit`, `ld_unknown` and `block_vec` are all 0.
- R2: A slot that is an active store, is older than the load, has its address known, and whose full address equals `ld_addr` blocks the load and raises `ld_hit`.
- R3: A slot that is an active store, is older than the load, and has its address not yet known blocks the load and raises `ld_unknown`, whatever address it holds.
- R4: A slot is older than the load when `(slot - head_idx) mod ENTRIES` is less than `(ld_idx - head_idx) mod ENTRIES`. A slot at or after the load in that order never blocks, including when the window wraps past slot ENTRIES-1.
- R5: A slot whose `retire_mask` bit is 1 never blocks in that cycle.
- R6: The address compare covers all ADDR_W bits, so a store address that differs from `ld_addr` in any single bit does not match.
- R7: A slot whose `st_valid` bit is 0 never blocks, whatever its address or known flag.
- R8: Bit i of `block_vec` is 1 exactly when slot i blocks the load. `ld_hit` and `ld_unknown` each report their own cause, and both may be 1 in the same cycle.
- R9: A load sitting at `head_idx` has no older slots and is never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_req | input | 1 | A load asks to start its memory access this cycle |
| ld_idx | input | IDX_W | Window slot of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| head_idx | input | IDX_W | Slot of the oldest uncommitted entry |
| st_valid | input | ENTRIES | Per slot: the slot holds an active store |
| st_addr_known | input | ENTRIES | Per slot: the store's address has been computed |
| st_addr_flat | input | ENTRIES*ADDR_W | Store addresses; slot i occupies bits [i*ADDR_W +: ADDR_W] |
| retire_mask | input | ENTRIES | Per slot: the slot commits or is flushed this cycle |
| ld_go | output | 1 | The load may access memory |
| ld_hit | output | 1 | Stall caused by an older store with an equal address |
| ld_unknown | output | 1 | Stall caused by an older store with an unresolved address |
| block_vec | output | ENTRIES | Per slot: this slot blocks the load |

## Verification
The gate is purely combinational, so any fault in the age mask or in a slot's compare appears on `block_vec` and `ld_go` in the same cycle as the stimulus. A wrong age mask shows up when the head sits beyond the load and the window wraps. In that case a younger matching store would block, or an older one would be let through. A narrowed compare or a missing retire or valid qualifier shows up as a wrong `ld_hit` on an address that differs in one bit, or on a slot that is leaving or empty. Each scenario is also checked against a walk from the head to the load, computed independently in the bench.

// File: rtl/ldchk_pkg.sv
package ldchk_pkg;

    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_ADDR_W  = 32;

    // Qualifiers describing one window slot, as seen by the gate
    typedef struct packed {
        logic is_store;   // slot holds an active store
        logic addr_rdy;   // store address has been computed
        logic leaving;    // slot commits or is flushed this cycle
    } slot_flags_t;

    // Combined decision for the pending load
    typedef struct packed {
        logic go;
        logic hit;
        logic unknown;
    } ld_verdict_t;

    // A slot can take part in the check only if it is a store that stays
    function automatic logic slot_live(slot_flags_t f);
        return f.is_store && !f.leaving;
    endfunction

endpackage

// File: rtl/ldchk_age_mask.sv
module ldchk_age_mask #(
    parameter int unsigned ENTRIES = ldchk_pkg::DEF_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0]   head_idx,
    input  logic [IDX_W-1:0]   ld_idx,
    output logic [ENTRIES-1:0] older
);
    // ENTRIES is a power of two, so IDX_W-bit subtraction wraps modulo ENTRIES
    logic [IDX_W-1:0] ld_dist;
    assign ld_dist = ld_idx - head_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [IDX_W-1:0] slot_dist;
        assign slot_dist = IDX_W'(g) - head_idx;
        assign older[g]  = slot_dist < ld_dist;
    end

    always_comb begin
        AST_LOAD_NOT_OLDER: assert (older[ld_idx] == 1'b0)
            else $error("load slot marked older than itself"); // R4
        AST_OLDER_COUNT: assert ($countones(older) == 32'(ld_dist))
            else $error("older slot count differs from ring distance"); // R9
    end

endmodule

// File: rtl/ldchk_slot_cmp.sv
module ldchk_slot_cmp
    import ldchk_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  slot_flags_t       flags,
    input  logic              older,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              hit,
    output logic              unknown
);
    logic in_scope;
    logic addr_eq;

    assign in_scope = slot_live(flags) && older;
    assign addr_eq  = (st_addr == ld_addr);
    assign hit      = in_scope && flags.addr_rdy && addr_eq;
    assign unknown  = in_scope && !flags.addr_rdy;

    always_comb begin
        AST_HIT_UNK_DISJOINT: assert (!(hit && unknown))
            else $error("slot reports both match and unknown"); // R8
        AST_LEAVING_QUIET: assert (!((hit || unknown) && flags.leaving))
            else $error("leaving slot still blocks"); // R5
        AST_EMPTY_QUIET: assert (!((hit || unknown) && !flags.is_store))
            else $error("non-store slot blocks"); // R7
    end

endmodule

// File: rtl/ldchk_merge.sv
module ldchk_merge
    import ldchk_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES
) (
    input  logic               ld_req,
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic [ENTRIES-1:0] unk_vec,
    output logic [ENTRIES-1:0] block_vec,
    output ld_verdict_t        verdict
);
    always_comb begin
        block_vec       = ld_req ? (hit_vec | unk_vec) : '0;
        verdict.hit     = ld_req && (|hit_vec);
        verdict.unknown = ld_req && (|unk_vec);
        verdict.go      = ld_req && !(verdict.hit || verdict.unknown);
    end

    always_comb begin
        AST_GO_CLEAR: assert (!(verdict.go && (block_vec != '0)))
            else $error("go asserted while a slot blocks"); // R1
        AST_CAUSE_NEEDS_SLOT: assert (!((verdict.hit || verdict.unknown) && (block_vec == '0)))
            else $error("stall cause without a blocking slot"); // R8
    end

endmodule

// File: rtl/ldcheck_gate.sv
module ldcheck_gate
    import ldchk_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      ld_req,
    input  logic [IDX_W-1:0]          ld_idx,
    input  logic [ADDR_W-1:0]         ld_addr,
    input  logic [IDX_W-1:0]          head_idx,
    input  logic [ENTRIES-1:0]        st_valid,
    input  logic [ENTRIES-1:0]        st_addr_known,
    input  logic [ENTRIES*ADDR_W-1:0] st_addr_flat,
    input  logic [ENTRIES-1:0]        retire_mask,
    output logic                      ld_go,
    output logic                      ld_hit,
    output logic                      ld_unknown,
    output logic [ENTRIES-1:0]        block_vec
);
    logic [ENTRIES-1:0] older;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] unk_vec;
    ld_verdict_t        verdict;

    ldchk_age_mask #(.ENTRIES(ENTRIES)) u_age (
        .head_idx (head_idx),
        .ld_idx   (ld_idx),
        .older    (older)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        slot_flags_t fl;
        assign fl.is_store = st_valid[g];
        assign fl.addr_rdy = st_addr_known[g];
        assign fl.leaving  = retire_mask[g];

        ldchk_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .flags   (fl),
            .older   (older[g]),
            .st_addr (st_addr_flat[g*ADDR_W +: ADDR_W]),
            .ld_addr (ld_addr),
            .hit     (hit_vec[g]),
            .unknown (unk_vec[g])
        );
    end

    ldchk_merge #(.ENTRIES(ENTRIES)) u_merge (
        .ld_req    (ld_req),
        .hit_vec   (hit_vec),
        .unk_vec   (unk_vec),
        .block_vec (block_vec),
        .verdict   (verdict)
    );

    assign ld_go      = verdict.go;
    assign ld_hit     = verdict.hit;
    assign ld_unknown = verdict.unknown;

    always_comb begin
        AST_IDLE_SILENT: assert (ld_req || (!ld_go && block_vec == '0))
            else $error("outputs active without a load request"); // R1
        AST_HEAD_LOAD_FREE: assert (!(ld_req && ld_idx == head_idx) || ld_go)
            else $error("load at head was stalled"); // R9
    end

endmodule

// File: tb/ldcheck_gate_test.sv
module ldcheck_gate_test;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          ld_req;
    logic [IW-1:0] ld_idx;
    logic [AW-1:0] ld_addr;
    logic [IW-1:0] head_idx;
    logic [N-1:0]  st_valid;
    logic [N-1:0]  st_addr_known;
    logic [N*AW-1:0] st_addr_flat;
    logic [N-1:0]  retire_mask;
    logic          ld_go, ld_hit, ld_unknown;
    logic [N-1:0]  block_vec;

    int total = 0;
    int bad   = 0;

    ldcheck_gate #(.ENTRIES(N), .ADDR_W(AW)) uut (
        .ld_req(ld_req), .ld_idx(ld_idx), .ld_addr(ld_addr), .head_idx(head_idx),
        .st_valid(st_valid), .st_addr_known(st_addr_known), .st_addr_flat(st_addr_flat),
        .retire_mask(retire_mask), .ld_go(ld_go), .ld_hit(ld_hit),
        .ld_unknown(ld_unknown), .block_vec(block_vec)
    );

    task automatic clear_all();
        ld_req = 0; ld_idx = '0; ld_addr = '0; head_idx = '0;
        st_valid = '0; st_addr_known = '0; st_addr_flat = '0; retire_mask = '0;
    endtask

    task automatic put_store(input int slot, input logic [AW-1:0] a, input logic known);
        st_valid[slot] = 1'b1;
        st_addr_known[slot] = known;
        st_addr_flat[slot*AW +: AW] = a;
    endtask

    // Independent model: walk forward from the head until the load slot
    task automatic model(output logic eg, output logic eh, output logic eu,
                         output logic [N-1:0] ev);
        int p;
        ev = '0; eh = 0; eu = 0;
        p = int'(head_idx);
        while (p != int'(ld_idx)) begin
            if (st_valid[p] && !retire_mask[p]) begin
                if (!st_addr_known[p]) begin eu = 1; ev[p] = 1; end
                else if (st_addr_flat[p*AW +: AW] == ld_addr) begin eh = 1; ev[p] = 1; end
            end
            p = (p + 1) % N;
        end
        if (!ld_req) begin ev = '0; eh = 0; eu = 0; end
        eg = ld_req && !(eh || eu);
    endtask

    task automatic check(input string req, input logic exp_go);
        logic eg, eh, eu;
        logic [N-1:0] ev;
        @(negedge clk);
        model(eg, eh, eu, ev);
        total++;
        if (eg !== exp_go) begin
            bad++;
            $display("FAIL %s: scenario expectation go=%0b, model go=%0b", req, exp_go, eg);
        end
        if (ld_go !== eg || ld_hit !== eh || ld_unknown !== eu || block_vec !== ev) begin
            bad++;
            $display("FAIL %s: got go=%0b hit=%0b unk=%0b vec=%b, expected go=%0b hit=%0b unk=%0b vec=%b",
                     req, ld_go, ld_hit, ld_unknown, block_vec, eg, eh, eu, ev);
        end
    endtask

    task automatic t_idle();               // R1
        clear_all();
        check("R1 idle", 1'b0);
        put_store(0, 32'h100, 1); ld_idx = 3; ld_addr = 32'h100;
        check("R1 no request", 1'b0);
        ld_req = 1; st_valid = '0;
        check("R1 clear go", 1'b1);
    endtask

    task automatic t_match();              // R2
        clear_all(); ld_req = 1; head_idx = 0; ld_idx = 4; ld_addr = 32'hDEAD_BEE0;
        put_store(2, 32'hDEAD_BEE0, 1);
        put_store(1, 32'h0000_1000, 1);
        check("R2 older match", 1'b0);
    endtask

    task automatic t_unknown();            // R3
        clear_all(); ld_req = 1; head_idx = 2; ld_idx = 6; ld_addr = 32'h40;
        put_store(3, 32'h9999, 0);
        check("R3 unknown older", 1'b0);
    endtask

    task automatic t_younger();            // R4
        clear_all(); ld_req = 1; head_idx = 0; ld_idx = 3; ld_addr = 32'h80;
        put_store(5, 32'h80, 1); put_store(3, 32'h80, 0); put_store(7, 32'h0, 0);
        check("R4 younger ignored", 1'b1);
        clear_all(); ld_req = 1; head_idx = 6; ld_idx = 1; ld_addr = 32'h80;
        put_store(7, 32'h80, 1);
        check("R4 wrap older", 1'b0);
        st_valid = '0; put_store(3, 32'h80, 1); put_store(5, 32'h80, 0);
        check("R4 wrap younger", 1'b1);
        put_store(0, 32'h80, 0);
        check("R4 wrap slot zero older", 1'b0);
    endtask

    task automatic t_retire();             // R5
        clear_all(); ld_req = 1; head_idx = 1; ld_idx = 5; ld_addr = 32'h2000;
        put_store(1, 32'h2000, 1);
        check("R5 before retire", 1'b0);
        retire_mask[1] = 1'b1;
        check("R5 retiring slot excluded", 1'b1);
    endtask

    task automatic t_bits();               // R6
        for (int b = 0; b < AW; b += 5) begin
            clear_all(); ld_req = 1; ld_idx = 2; ld_addr = 32'hA5A5_5A5A;
            put_store(0, ld_addr ^ (32'h1 << b), 1);
            check("R6 single bit differs", 1'b1);
        end
        clear_all(); ld_req = 1; ld_idx = 2; ld_addr = 32'hA5A5_5A5A;
        put_store(0, ld_addr ^ 32'h8000_0000, 1);
        check("R6 top bit differs", 1'b1);
    endtask

    task automatic t_invalid();            // R7
        clear_all(); ld_req = 1; head_idx = 0; ld_idx = 7; ld_addr = 32'h55;
        for (int i = 0; i < 7; i++) st_addr_flat[i*AW +: AW] = 32'h55;
        st_addr_known = 8'h0F;
        check("R7 empty slots ignored", 1'b1);
    endtask

    task automatic t_both();               // R8
        clear_all(); ld_req = 1; head_idx = 4; ld_idx = 2; ld_addr = 32'h300;
        put_store(5, 32'h300, 1); put_store(0, 32'h0, 0); put_store(6, 32'h301, 1);
        check("R8 both causes", 1'b0);
    endtask

    task automatic t_head();               // R9
        clear_all(); ld_req = 1; head_idx = 5; ld_idx = 5; ld_addr = 32'h77;
        for (int i = 0; i < N; i++) if (i != 5) put_store(i, 32'h77, (i % 2) == 0);
        check("R9 load at head", 1'b1);
    endtask

    task automatic t_sweep();              // R8 mixed patterns
        logic [31:0] lf = 32'h1357_9BDF;
        logic eg, eh, eu;
        logic [N-1:0] ev;
        for (int k = 0; k < 200; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            ld_req = lf[0]; ld_idx = lf[3:1]; head_idx = lf[6:4];
            st_valid = lf[14:7]; st_addr_known = lf[22:15]; retire_mask = {lf[25:23], 5'b0} & lf[30:23];
            ld_addr = {30'h0, lf[27:26]};
            for (int i = 0; i < N; i++) st_addr_flat[i*AW +: AW] = {30'h0, lf[i*3 % 30 +: 2]};
            #1; model(eg, eh, eu, ev);
            check("R8 sweep", eg);
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_all();
        repeat (2) @(posedge clk);
        t_idle();
        t_match();
        t_unknown();
        t_younger();
        t_retire();
        t_bits();
        t_invalid();
        t_both();
        t_head();
        t_sweep();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule